// File: doc/BRIEF.md
# Retention Upset Localizer for Clock-Gated Modules

This block guards the state that a module keeps while its clock is switched off for a long idle stretch. It watches every register of the guarded module through one flat data bus. When a gate request arrives, it reduces each register to a single parity bit. It also folds those bits into a short checksum: each register contributes its one-based position, combined by XOR over the registers whose parity is one. It keeps both the parity vector and the checksum, then grants the gate.

On wake-up it computes both values again from the live data. A mismatch in any register parity raises an error. When exactly one register is hit, the XOR of the stored and fresh checksums names that register, so the surrounding logic can recompute it. When two or more registers are hit, the location cannot be trusted, so the block flags that case and withholds the index. Per-bit correction is left to the caller.

Top module: `upset_localizer`

## Requirements
- R1: After reset, gate_ack, check_done, error, multi_error and loc_valid are low, and location is 0.
- R2: When gate_req is sampled high while not gated, gate_ack goes high on the next cycle and stays high until a wake is taken. The snapshot uses reg_data as sampled on the same edge as gate_req.
- R3: When wake is sampled high while gated, check_done is high for exactly the next cycle, and gate_ack falls in that same cycle.
- R4: error is high after a check if and only if the XOR of all bits of at least one register (register i occupies reg_data[i*WIDTH +: WIDTH]) differs between the snapshot and the wake data.
- R5: When exactly one register parity differs, loc_valid is 1, multi_error is 0, and location is the zero-based index of that register.
- R6: When two or more register parities differ, multi_error is 1, loc_valid is 0, and location is 0.
- R7: An even number of bit flips inside one register leaves that register's parity unchanged, so by itself it raises no error.
- R8: wake while not gated, and gate_req while gated, produce no check_done and do not change gate_ack.
- R9: error, multi_error, loc_valid and location hold their values until the next check_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_data | input | NREG*WIDTH | Contents of the guarded registers, register i at bits i*WIDTH upward |
| gate_req | input | 1 | Request to snapshot the state and allow clock gating |
| wake | input | 1 | Indicates the module has left the gated phase; starts the check |
| gate_ack | output | 1 | Snapshot held; the clock may be gated |
| check_done | output | 1 | One-cycle pulse when the check results are updated |
| error | output | 1 | At least one register parity changed |
| multi_error | output | 1 | More than one register parity changed |
| loc_valid | output | 1 | location names the single faulty register |
| location | output | max(1,clog2(NREG)) | Zero-based index of the faulty register |

## Verification
Each result is due one cycle after its request edge. gate_ack must be high one cycle after gate_req is sampled. check_done and the four result outputs must be updated one cycle after wake is sampled. The bench drives inputs on falling edges and reads the outputs on the next falling edge, half a cycle after the edge that should have updated them. It then reads them again one cycle later to confirm the pulse has ended and the results are held.

// File: rtl/upset_localizer.sv
module upset_localizer #(
  parameter int NREG  = 8,
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG*WIDTH-1:0] reg_data,
  input  logic                  gate_req,
  input  logic                  wake,
  output logic                  gate_ack,
  output logic                  check_done,
  output logic                  error,
  output logic                  multi_error,
  output logic                  loc_valid,
  output logic [((NREG>1)?$clog2(NREG):1)-1:0] location
);
  localparam int CW = $clog2(NREG + 1);
  localparam int LW = (NREG > 1) ? $clog2(NREG) : 1;

  function automatic logic [NREG-1:0] weight_mask(input int b);
    logic [NREG-1:0] m;
    for (int i = 0; i < NREG; i++) m[i] = ((i + 1) >> b) & 1;
    return m;
  endfunction

  logic [NREG-1:0] par_now, par_snap, diff;
  logic [CW-1:0]   chk_now, chk_snap, syn;
  logic            any_hit, one_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_par
    assign par_now[i] = ^reg_data[i*WIDTH +: WIDTH];
  end

  for (genvar b = 0; b < CW; b++) begin : g_chk
    assign chk_now[b] = ^(par_now & weight_mask(b));
  end

  assign diff    = par_now ^ par_snap;
  assign syn     = chk_now ^ chk_snap;
  assign any_hit = |diff;
  assign one_hit = any_hit && ((diff & (diff - 1'b1)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_ack    <= 1'b0;
      par_snap    <= '0;
      chk_snap    <= '0;
      check_done  <= 1'b0;
      error       <= 1'b0;
      multi_error <= 1'b0;
      loc_valid   <= 1'b0;
      location    <= '0;
    end else begin
      check_done <= 1'b0;
      if (!gate_ack) begin
        if (gate_req) begin
          par_snap <= par_now;
          chk_snap <= chk_now;
          gate_ack <= 1'b1;
        end
      end else if (wake) begin
        gate_ack    <= 1'b0;
        check_done  <= 1'b1;
        error       <= any_hit;
        multi_error <= any_hit && !one_hit;
        loc_valid   <= one_hit;
        location    <= one_hit ? LW'(syn - 1'b1) : '0;
      end
    end
  end

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_ack && gate_req) |=> gate_ack);

  assert_done_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    check_done |=> !check_done);

  assert_done_drops_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ack && wake) |=> (check_done && !gate_ack));

  assert_multi_hides_loc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    multi_error |-> (!loc_valid && location == '0));

  assert_loc_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> (error && int'(location) < NREG));

  assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !check_done |-> ($stable(error) && $stable(multi_error) && $stable(loc_valid)
                     && $stable(location)));
endmodule

// File: tb/sim_upset_localizer.sv
`timescale 1ns/1ps
module sim_upset_localizer;
  localparam int NREG  = 8;
  localparam int WIDTH = 16;
  localparam int LW    = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREG*WIDTH-1:0] reg_data = '0;
  logic gate_req = 1'b0, wake = 1'b0;
  logic gate_ack, check_done, error, multi_error, loc_valid;
  logic [LW-1:0] location;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  upset_localizer #(.NREG(NREG), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_data(reg_data), .gate_req(gate_req), .wake(wake),
    .gate_ack(gate_ack), .check_done(check_done), .error(error),
    .multi_error(multi_error), .loc_valid(loc_valid), .location(location));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NREG-1:0] parities(input logic [NREG*WIDTH-1:0] d);
    logic [NREG-1:0] p;
    for (int i = 0; i < NREG; i++) p[i] = ^d[i*WIDTH +: WIDTH];
    return p;
  endfunction

  task automatic run_check(input logic [NREG*WIDTH-1:0] snap,
                           input logic [NREG*WIDTH-1:0] live, input int idle_cycles);
    logic [NREG-1:0] d;
    int n, idx;
    d = parities(snap) ^ parities(live);
    n = $countones(d);
    idx = 0;
    for (int i = 0; i < NREG; i++) if (d[i]) idx = i;
    @(negedge clk); reg_data = snap; gate_req = 1'b1;
    @(negedge clk); gate_req = 1'b0; reg_data = live;
    chk(gate_ack === 1'b1, "R2 gate_ack", gate_ack, 1);
    for (int k = 0; k < idle_cycles; k++) begin
      gate_req = 1'b1;
      @(negedge clk);
      gate_req = 1'b0;
      chk(gate_ack === 1'b1 && check_done === 1'b0, "R8 gate_req while gated",
          {gate_ack, check_done}, 2);
    end
    wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    chk(check_done === 1'b1, "R3 check_done", check_done, 1);
    chk(gate_ack === 1'b0, "R3 gate_ack drop", gate_ack, 0);
    chk(error === (n > 0), "R4 error", error, int'(n > 0));
    if (n == 1) begin
      chk(loc_valid === 1'b1 && multi_error === 1'b0, "R5 flags",
          {multi_error, loc_valid}, 1);
      chk(int'(location) == idx, "R5 location", location, idx);
    end else if (n > 1) begin
      chk(multi_error === 1'b1 && loc_valid === 1'b0 && location == '0, "R6 multi",
          {multi_error, loc_valid, location}, 2 << LW);
    end else begin
      chk(multi_error === 1'b0 && loc_valid === 1'b0, "R4 clean", {multi_error, loc_valid}, 0);
    end
    @(negedge clk);
    chk(check_done === 1'b0, "R3 pulse ends", check_done, 0);
    chk(error === (n > 0) && loc_valid === (n == 1) && multi_error === (n > 1),
        "R9 hold", {error, multi_error, loc_valid},
        {int'(n > 0), int'(n > 1), int'(n == 1)});
  endtask

  function automatic logic [NREG*WIDTH-1:0] rnd_data();
    logic [NREG*WIDTH-1:0] d;
    for (int i = 0; i < NREG*WIDTH; i += 32) d[i +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NREG*WIDTH-1:0] s, l;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk({gate_ack, check_done, error, multi_error, loc_valid} === 5'b0 && location == '0,
        "R1 reset", {gate_ack, check_done, error, multi_error, loc_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    @(negedge clk);
    chk(check_done === 1'b0 && gate_ack === 1'b0, "R8 wake while idle",
        {gate_ack, check_done}, 0);

    s = rnd_data();
    run_check(s, s, 0);
    l = s; l[0] = ~l[0];
    run_check(s, l, 1);
    l = s; l[NREG*WIDTH-1] = ~l[NREG*WIDTH-1];
    run_check(s, l, 0);
    l = s; l[3*WIDTH + 2] = ~l[3*WIDTH + 2]; l[3*WIDTH + 9] = ~l[3*WIDTH + 9];
    run_check(s, l, 0);
    chk(error === 1'b0, "R7 even flips unseen", error, 0);
    l = s; l[1*WIDTH] = ~l[1*WIDTH]; l[6*WIDTH + 5] = ~l[6*WIDTH + 5];
    run_check(s, l, 2);

    for (int t = 0; t < 200; t++) begin
      s = rnd_data();
      l = s;
      for (int f = 0, nf = $urandom_range(0, 3); f < nf; f++) begin
        int r;
        r = $urandom_range(0, NREG*WIDTH-1);
        l[r] = ~l[r];
      end
      run_check(s, l, $urandom_range(0, 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule